// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes every instruction in a single clock cycle. In one cycle it fetches the word at the program counter, decodes it, reads two source registers, runs the arithmetic unit, optionally accesses data memory, writes a result register and selects the next program counter. It supports seven operations: unsigned add and subtract between registers, OR with an immediate, word load, word store, branch on equal and an absolute jump.

Instruction and data storage are internal word arrays. Both read combinationally and write on the clock edge. A testbench fills them before reset is released. Debug outputs show the current program counter and the register write taking effect at the coming edge. An external checker can therefore follow each instruction as it completes.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter is held at 0 and no register or memory write occurs. The first instruction after reset is fetched from byte address 0, and the program counter always stays word aligned.
- R2: For opcode 0, funct 0x21 writes rs+rt and funct 0x23 writes rs-rt, both modulo 2^32, to register rd. The program counter then advances by 4.
- R3: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate to register rt.
- R4: Opcode 0x23 loads the data word at rs plus the sign-extended immediate into rt. Opcode 0x2B stores rt to that address and writes no register.
- R5: Opcode 0x04 compares rs with rt. When they are equal, the next program counter is PC+4 plus the sign-extended immediate times 4. Otherwise it is PC+4.
- R6: Opcode 0x02 sets the program counter to the upper four bits of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R7: Register 0 always reads as zero. A write aimed at it is discarded, and `dbg_wr_en` stays low for that write.
- R8: An instruction that reads and writes the same register in one cycle uses the value the register held before that cycle.
- R9: Memories are indexed by address bits above bit 1, so the two low address bits of a load or store have no effect.
- R10: Any other opcode, and any other funct under opcode 0, writes nothing and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register write happens at the coming edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |

## Verification
Two activities can land in the same cycle. One is reading a source register while the same register is rewritten. The other is loading a word at an address that a store updated one cycle earlier, or with the address's low bits set. The program includes an add whose destination is also its source, and a load that follows a store to the same word. A behavioural model predicts the pre-edge operand value and the stored data, and on every cycle the debug port must show exactly that value. Taken, untaken and backward branches, the jump and an unknown opcode are also checked against the model's program counter.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RAW    = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_we;
    logic    mem_we;
    logic    is_branch;
    logic    is_jump;
    logic    imm_signed;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        if (funct == FN_ADDU || funct == FN_SUBU) begin
          ctrl.dst_is_rd = 1'b1;
          ctrl.reg_we    = 1'b1;
          ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.reg_we   = 1'b1;
        ctrl.b_is_imm = 1'b1;
        ctrl.alu_op   = ALU_OR;
      end
      OP_LW: begin
        ctrl.reg_we      = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.imm_signed  = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we     = 1'b1;
        ctrl.b_is_imm   = 1'b1;
        ctrl.imm_signed = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OP_J:    ctrl.is_jump = 1'b1;
      default: ctrl = ctrl;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (we && wa != '0) rf[wa] <= wd;
  end

  assign qa = (ra == '0) ? '0 : rf[ra];
  assign qb = (rb == '0) ? '0 : rf[rb];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic         clk,
  input  logic         we,
  input  logic [31:0]  addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mem [WORDS];
  logic [IW-1:0] idx;

  assign idx = addr[IW+1:2];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          IMEM_WORDS = 64,
  parameter int          DMEM_WORDS = 64,
  parameter logic [31:0] RESET_PC   = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [31:0]     dbg_pc,
  output logic            dbg_wr_en,
  output logic [RAW-1:0]  dbg_wr_addr,
  output logic [XLEN-1:0] dbg_wr_data
);
  logic [31:0]     pc_q, pc_plus4, br_target, jmp_target, pc_next;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] bus_a, bus_b, ext_imm, alu_b, alu_y, mem_rd, wb_data;
  logic            alu_zero, wr_en;
  logic [RAW-1:0]  wr_addr;

  sc_mem #(.W(32), .WORDS(IMEM_WORDS)) u_imem (
    .clk(clk), .we(1'b0), .addr(pc_q), .wdata(32'h0), .rdata(instr)
  );

  sc_decode u_dec (.op(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  assign wr_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign wr_en   = ctrl.reg_we && !rst && (wr_addr != '0);

  sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wb_data),
    .ra(instr[25:21]), .rb(instr[20:16]), .qa(bus_a), .qb(bus_b)
  );

  assign ext_imm = ctrl.imm_signed ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                                   : {{(XLEN-16){1'b0}}, instr[15:0]};
  assign alu_b   = ctrl.b_is_imm ? ext_imm : bus_b;

  sc_alu #(.W(XLEN)) u_alu (
    .op(ctrl.alu_op), .a(bus_a), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  sc_mem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk(clk), .we(ctrl.mem_we && !rst), .addr(alu_y), .wdata(bus_b),
    .rdata(mem_rd)
  );

  assign wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;

  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)                   pc_next = jmp_target;
    else if (ctrl.is_branch && alu_zero) pc_next = br_target;
    else                                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wr_en;
  assign dbg_wr_addr = wr_addr;
  assign dbg_wr_data = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] bus_a,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [31:0] wr_data
);
  logic [31:0] seq_pc, jmp_exp;
  logic [5:0]  op;
  assign op      = instr[31:26];
  assign seq_pc  = pc + 32'd4;
  assign jmp_exp = {seq_pc[31:28], instr[25:0], 2'b00};

  assert_reset_pc_R1: assert property (@(posedge clk) rst |=> (pc == 32'h0));
  assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
  assert_rtype_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h00) |=> (pc == $past(seq_pc)));
  assert_ori_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h0D && wr_en) |-> (wr_data[31:16] == bus_a[31:16]));
  assert_store_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h2B) |-> !wr_en);
  assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> (pc == $past(jmp_exp)));
  assert_no_r0_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != 5'd0));
endmodule

bind sc_core sc_core_chk chk_i (
  .clk(clk), .rst(rst), .pc(dbg_pc), .instr(instr), .bus_a(bus_a),
  .wr_en(dbg_wr_en), .wr_addr(dbg_wr_addr), .wr_data(dbg_wr_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 64;
  localparam int RUN_CYCLES = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;
  logic [31:0] dbg_wr_data;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] prog   [WORDS];
  logic [31:0] m_dmem [WORDS];
  logic [31:0] m_regs [32];
  logic [31:0] m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
    .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at t=%0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // Behavioural model: predict this cycle's write and next PC, then commit.
  task automatic model_step();
    logic [31:0] ins, a, b, addr, wd, npc;
    logic        we, st;
    int          dst;
    string       req;
    ins = prog[m_pc[7:2]];
    a   = m_regs[ins[25:21]];
    b   = m_regs[ins[20:16]];
    we  = 1'b0; st = 1'b0; dst = 0; wd = '0; addr = '0;
    npc = m_pc + 4;
    req = "R10";
    case (ins[31:26])
      6'h00: if (ins[5:0] == 6'h21) begin
               we = 1'b1; dst = ins[15:11]; wd = a + b; req = "R2_R8";
             end else if (ins[5:0] == 6'h23) begin
               we = 1'b1; dst = ins[15:11]; wd = a - b; req = "R2";
             end
      6'h0D: begin we = 1'b1; dst = ins[20:16]; wd = a | {16'h0, ins[15:0]}; req = "R3"; end
      6'h23: begin
               addr = a + {{16{ins[15]}}, ins[15:0]};
               we = 1'b1; dst = ins[20:16]; wd = m_dmem[addr[7:2]]; req = "R4_R9";
             end
      6'h2B: begin addr = a + {{16{ins[15]}}, ins[15:0]}; st = 1'b1; req = "R4"; end
      6'h04: begin
               req = "R5";
               if (a == b) npc = m_pc + 4 + {{14{ins[15]}}, ins[15:0], 2'b00};
             end
      6'h02: begin req = "R6"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      default: req = "R10";
    endcase
    if (dst == 0) begin
      if (we) req = "R7";
      we = 1'b0;
    end
    check(req, "pc", dbg_pc, m_pc);
    check(req, "wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
    if (we) begin
      check(req, "wr_addr", {27'd0, dbg_wr_addr}, dst);
      check(req, "wr_data", dbg_wr_data, wd);
    end
    if (we) m_regs[dst] = wd;
    if (st) m_dmem[addr[7:2]] = b;
    m_pc = npc;
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      prog[i] = 32'hFC00_0000;
      m_dmem[i] = 32'h1000_0000 + i;
    end
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_dmem[1] = 32'hCAFE_F00D;
    prog[0]  = enc_i(6'h0D, 0, 1, 16'h8001);
    prog[1]  = enc_i(6'h0D, 0, 2, 16'h0010);
    prog[2]  = enc_r(1, 2, 3, 6'h21);
    prog[3]  = enc_r(2, 1, 4, 6'h23);
    prog[4]  = enc_r(1, 1, 1, 6'h21);
    prog[5]  = enc_i(6'h2B, 2, 3, 16'h0004);
    prog[6]  = enc_i(6'h23, 2, 6, 16'h0004);
    prog[7]  = enc_i(6'h23, 2, 7, 16'hFFF6);
    prog[8]  = enc_i(6'h0D, 0, 0, 16'h1234);
    prog[9]  = enc_r(0, 2, 8, 6'h21);
    prog[10] = enc_i(6'h04, 3, 6, 16'h0002);
    prog[11] = enc_i(6'h0D, 0, 9, 16'h0001);
    prog[12] = enc_i(6'h0D, 0, 9, 16'h0002);
    prog[13] = enc_i(6'h04, 1, 2, 16'h0005);
    prog[14] = 32'hFC00_0000;
    prog[15] = {6'h02, 26'd20};
    prog[16] = enc_r(1, 2, 10, 6'h3F);
    prog[20] = enc_i(6'h0D, 0, 11, 16'hFFFF);
    prog[21] = enc_i(6'h04, 0, 0, 16'hFFFF);
    for (int i = 0; i < WORDS; i++) begin
      dut_i.u_imem.mem[i] = prog[i];
      dut_i.u_dmem.mem[i] = m_dmem[i];
    end
    m_pc = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset pc", dbg_pc, 32'h0);
    check("R1", "reset wr_en", {31'd0, dbg_wr_en}, 32'd0);
    rst = 1'b0;
    #1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      model_step();
      @(negedge clk);
      #1;
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule